// File: doc/BRIEF.md
# Flash Page-Erase and Byte-Write Sequencer

This block sequences the two destructive operations of an on-chip electrically erasable program memory. Software loads a 16-bit address pointer and a data byte through a small register write port. It then writes a command code into the control register. One code starts a single-byte write. The other erases the 32-byte page that contains the pointer. The block then holds `busy` for a fixed number of ticks from an external timebase. The erase interval is longer than the write interval. When the interval ends, the block changes the memory contents, drops `busy` and pulses `done`.

The control register keeps its value after an operation. Software is expected to write 00H to it once the operation is over. A new operation starts only when the control register is written, so an old code left in the register never starts a second operation. Software reads the array back through a request/response stream to verify a written byte.

Read back has two streams, request and response, and each moves data on the cycle that valid and ready are both high. Only one read is outstanding at a time. A request is accepted only when the block is not busy and the response slot is empty or is being drained in that cycle. A response stays valid, with its data unchanged, until `rs_ready` takes it. A consumer that holds `rs_ready` low therefore stalls the request side.

Top module: `fmem_seq`

## Requirements
- R1: After reset, `busy`, `done`, `rs_valid` and `ctl_q` are 0, `rq_ready` is 1, and every array location reads FFH.
- R2: When the block is idle, writing 45H to the control register (`reg_sel` = 0) raises `busy` on the next cycle. `busy` then stays high for exactly WRITE_TICKS cycles in which `tick` is high.
- R3: When the block is idle, writing 4CH to the control register raises `busy` on the next cycle. `busy` then stays high for exactly ERASE_TICKS ticks.
- R4: A byte write stores the data register (`reg_sel` = 3) at the pointer. The pointer low byte is written with `reg_sel` = 1 and the high byte with `reg_sel` = 2. Only the low MEM_AW pointer bits select a location, so addresses alias modulo 2^MEM_AW.
- R5: A page erase sets to FFH the 32 locations from the pointer rounded down to a 32-byte boundary through that base plus 31. Pointer bits [4:0] are ignored, and locations outside the page keep their contents.
- R6: `done` is high for exactly one cycle per operation. That cycle is the first one in which `busy` is low again, and the array already holds the new contents in that cycle.
- R7: While `busy` is high, every register write is ignored, including command, pointer and data writes. `ctl_q` and the operation in progress are unchanged.
- R8: Any other control value is stored and shown on `ctl_q` but starts nothing. A code stays in `ctl_q` after its operation ends and does not start it again. Writing 00H clears `ctl_q`.
- R9: `rq_ready` is low while `busy` is high. A response stays valid with stable data until it is accepted. The response carries the byte at `rq_addr` (low MEM_AW bits), and at most one response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timebase strobe that times the busy interval |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 pointer low, 2 pointer high, 3 data |
| reg_wdata | input | 8 | Register write data |
| ctl_q | output | 8 | Current control register value |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rq_valid | input | 1 | Read request valid |
| rq_ready | output | 1 | Read request accepted |
| rq_addr | input | 16 | Read request address |
| rs_valid | output | 1 | Read response valid |
| rs_ready | input | 1 | Read response taken |
| rs_data | output | 8 | Read response byte |

## Verification
The assertions check, on every cycle, the rules at the edges of the block. `busy` may rise only after a write of one of the two codes to the control register. `done` must be a single pulse outside `busy`. Register writes during `busy` must leave `ctl_q` alone. The read response must hold under back-pressure, and requests must be refused while `busy`.

Only the bench scenarios can show the parts that depend on array contents and on tick counts. These are the exact erase and write durations, the page boundaries of an erase, address aliasing, and the survival of the original pointer and data when writes arrive during an operation.

// File: rtl/fmseq_pkg.sv
package fmseq_pkg;
  localparam logic [7:0] CODE_PAGE_ERASE = 8'h4C;
  localparam logic [7:0] CODE_BYTE_WRITE = 8'h45;
  localparam logic [7:0] ERASED_BYTE     = 8'hFF;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_PTR_LO = 2'd1,
    SEL_PTR_HI = 2'd2,
    SEL_DATA   = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_BYTE = 2'd1,
    OP_PAGE = 2'd2
  } op_e;
endpackage

// File: rtl/fmseq_regs.sv
module fmseq_regs
  import fmseq_pkg::*;
#(
  parameter int PTR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       sel,
  input  logic [7:0]       wdata,
  input  logic             busy,
  output logic [7:0]       ctl_q,
  output logic [PTR_W-1:0] ptr_q,
  output logic [7:0]       dat_q,
  output logic             start,
  output op_e              start_op
);
  localparam int HI_W = PTR_W - 8;

  logic accept;
  assign accept = wr_en && !busy;

  // Command decode: only a fresh write of a defined code starts anything.
  always_comb begin
    start_op = OP_IDLE;
    if (accept && reg_sel_e'(sel) == SEL_CTRL) begin
      if (wdata == CODE_BYTE_WRITE)      start_op = OP_BYTE;
      else if (wdata == CODE_PAGE_ERASE) start_op = OP_PAGE;
    end
  end
  assign start = (start_op != OP_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      ptr_q <= '0;
      dat_q <= '0;
    end else if (accept) begin
      case (reg_sel_e'(sel))
        SEL_CTRL:   ctl_q <= wdata;
        SEL_PTR_LO: ptr_q[7:0] <= wdata;
        SEL_PTR_HI: ptr_q[PTR_W-1:8] <= wdata[HI_W-1:0];
        default:    dat_q <= wdata;
      endcase
    end
  end
endmodule

// File: rtl/fmseq_timer.sv
module fmseq_timer
  import fmseq_pkg::*;
#(
  parameter int ERASE_TICKS = 5000,
  parameter int WRITE_TICKS = 2500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  start_op,
  input  logic tick,
  output logic busy,
  output logic done,
  output logic commit,
  output op_e  op_q
);
  localparam int MAX_T = (ERASE_TICKS > WRITE_TICKS) ? ERASE_TICKS : WRITE_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  logic [CNT_W-1:0] cnt;

  assign commit = busy && tick && (cnt == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      op_q <= OP_IDLE;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        op_q <= start_op;
        cnt  <= (start_op == OP_PAGE) ? CNT_W'(ERASE_TICKS) : CNT_W'(WRITE_TICKS);
      end else if (busy && tick) begin
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
          op_q <= OP_IDLE;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/fmseq_array.sv
module fmseq_array
  import fmseq_pkg::*;
#(
  parameter int MEM_AW     = 10,
  parameter int PAGE_BYTES = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  op_e               op,
  input  logic [MEM_AW-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic              rd_fire,
  input  logic [MEM_AW-1:0] rd_addr,
  output logic [7:0]        rd_data
);
  localparam int DEPTH = 1 << MEM_AW;
  localparam int PG_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = MEM_AW - PG_W;

  logic [7:0] mem [DEPTH];
  logic [BASE_W-1:0] page_base;

  assign page_base = wr_addr[MEM_AW-1:PG_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED_BYTE;
    end else if (commit) begin
      if (op == OP_PAGE) begin
        for (int j = 0; j < PAGE_BYTES; j++)
          mem[{page_base, PG_W'(j)}] <= ERASED_BYTE;
      end else if (op == OP_BYTE) begin
        mem[wr_addr] <= wr_data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_fire) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/fmseq_rdport.sv
module fmseq_rdport (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic rq_valid,
  output logic rq_ready,
  output logic rs_valid,
  input  logic rs_ready,
  output logic rd_fire
);
  assign rq_ready = !busy && (!rs_valid || rs_ready);
  assign rd_fire  = rq_valid && rq_ready;

  always_ff @(posedge clk) begin
    if (!rst_n)        rs_valid <= 1'b0;
    else if (rd_fire)  rs_valid <= 1'b1;
    else if (rs_ready) rs_valid <= 1'b0;
  end
endmodule

// File: rtl/fmem_seq.sv
module fmem_seq
  import fmseq_pkg::*;
#(
  parameter int PTR_W       = 16,
  parameter int MEM_AW      = 10,
  parameter int PAGE_BYTES  = 32,
  parameter int ERASE_TICKS = 5000,
  parameter int WRITE_TICKS = 2500
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        reg_wr,
  input  logic [1:0]  reg_sel,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  ctl_q,
  output logic        busy,
  output logic        done,
  input  logic        rq_valid,
  output logic        rq_ready,
  input  logic [15:0] rq_addr,
  output logic        rs_valid,
  input  logic        rs_ready,
  output logic [7:0]  rs_data
);
  logic [PTR_W-1:0] ptr_q;
  logic [7:0]       dat_q;
  logic             start;
  op_e              start_op;
  op_e              op_q;
  logic             commit;
  logic             rd_fire;

  fmseq_regs #(.PTR_W(PTR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
    .busy(busy), .ctl_q(ctl_q), .ptr_q(ptr_q), .dat_q(dat_q),
    .start(start), .start_op(start_op)
  );

  fmseq_timer #(.ERASE_TICKS(ERASE_TICKS), .WRITE_TICKS(WRITE_TICKS)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .start_op(start_op), .tick(tick),
    .busy(busy), .done(done), .commit(commit), .op_q(op_q)
  );

  fmseq_array #(.MEM_AW(MEM_AW), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .commit(commit), .op(op_q),
    .wr_addr(ptr_q[MEM_AW-1:0]), .wr_data(dat_q),
    .rd_fire(rd_fire), .rd_addr(rq_addr[MEM_AW-1:0]), .rd_data(rs_data)
  );

  fmseq_rdport u_rdport (
    .clk(clk), .rst_n(rst_n), .busy(busy), .rq_valid(rq_valid),
    .rq_ready(rq_ready), .rs_valid(rs_valid), .rs_ready(rs_ready), .rd_fire(rd_fire)
  );
endmodule

// File: rtl/fmseq_chk.sv
module fmseq_chk
  import fmseq_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [1:0] reg_sel,
  input logic [7:0] reg_wdata,
  input logic [7:0] ctl_q,
  input logic       busy,
  input logic       done,
  input logic       rq_ready,
  input logic       rs_valid,
  input logic       rs_ready,
  input logic [7:0] rs_data
);
  // R2 R3 R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel == 2'd0 &&
                          (reg_wdata == CODE_BYTE_WRITE || reg_wdata == CODE_PAGE_ERASE)));

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  // R7
  ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr) |=> $stable(ctl_q));

  // R9
  rq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rq_ready);

  // R9
  rs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_valid && !rs_ready) |=> (rs_valid && $stable(rs_data)));
endmodule

bind fmem_seq fmseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
  .ctl_q(ctl_q), .busy(busy), .done(done), .rq_ready(rq_ready),
  .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data)
);

// File: tb/tb_fmem_seq.sv
module tb_fmem_seq;
  localparam int ET = 6;
  localparam int WT = 3;
  localparam int TICK_GAP = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] ctl_q;
  logic busy, done;
  logic rq_valid = 1'b0;
  logic rq_ready;
  logic [15:0] rq_addr = '0;
  logic rs_valid;
  logic rs_ready = 1'b1;
  logic [7:0] rs_data;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  fmem_seq #(.ERASE_TICKS(ET), .WRITE_TICKS(WT)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctl_q(ctl_q), .busy(busy), .done(done),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_addr(rq_addr),
    .rs_valid(rs_valid), .rs_ready(rs_ready), .rs_data(rs_data)
  );

  // timebase strobe, driven just after the edge
  initial begin
    forever begin
      repeat (TICK_GAP - 1) @(posedge clk);
      #1 tick = 1'b1;
      @(posedge clk);
      #1 tick = 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rs_valid && rs_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected response", int'(rs_data), 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rs_data == e, t, "read data", int'(rs_data), int'(e));
      end
    end
  end

  task automatic wr_reg(input logic [1:0] s, input logic [7:0] v);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(posedge clk); #1;
    rq_valid = 1'b1; rq_addr = a;
    do @(negedge clk); while (!rq_ready);
    @(posedge clk); #1;
    rq_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (exp_q.size() != 0 && guard < 100) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    check(exp_q.size() == 0, "R9", "responses outstanding", exp_q.size(), 0);
  endtask

  task automatic cmd(input logic [7:0] code, input int exp_ticks, input string t);
    int n = 0;
    int guard = 0;
    wr_reg(2'd0, code);
    @(negedge clk);
    check(busy == 1'b1, t, "busy after command", int'(busy), 1);
    while (busy && guard < 1000) begin
      if (tick) n++;
      @(negedge clk);
      guard++;
    end
    check(n == exp_ticks, t, "busy tick count", n, exp_ticks);
    check(done == 1'b1, "R6", "done in first idle cycle", int'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R6", "done single cycle", int'(done), 0);
  endtask

  task automatic set_ptr(input logic [15:0] a);
    wr_reg(2'd1, a[7:0]);
    wr_reg(2'd2, a[15:8]);
  endtask

  task automatic wbyte(input logic [15:0] a, input logic [7:0] v);
    set_ptr(a);
    wr_reg(2'd3, v);
    cmd(8'h45, WT, "R2");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 1'b0, "R1", "busy", int'(busy), 0);
    check(done == 1'b0, "R1", "done", int'(done), 0);
    check(rs_valid == 1'b0, "R1", "rs_valid", int'(rs_valid), 0);
    check(ctl_q == 8'h00, "R1", "ctl_q", int'(ctl_q), 0);
    check(rq_ready == 1'b1, "R1", "rq_ready", int'(rq_ready), 1);
    rd(16'h0000, 8'hFF, "R1");
    rd(16'h03FF, 8'hFF, "R1");
    drain();

    // R2 R4 byte write, read back directly and through an alias
    wbyte(16'h0123, 8'hA5);
    check(ctl_q == 8'h45, "R8", "code retained", int'(ctl_q), 8'h45);
    rd(16'h0123, 8'hA5, "R4");
    rd(16'h0523, 8'hA5, "R4");
    drain();
    wr_reg(2'd0, 8'h00);
    @(negedge clk);
    check(ctl_q == 8'h00, "R8", "cleared", int'(ctl_q), 0);

    // R5 page erase around page 0x260..0x27F
    wbyte(16'h025F, 8'h11);
    wbyte(16'h0260, 8'h22);
    wbyte(16'h0263, 8'h33);
    wbyte(16'h027F, 8'h44);
    wbyte(16'h0280, 8'h55);
    set_ptr(16'h1263);
    cmd(8'h4C, ET, "R3");
    rd(16'h025F, 8'h11, "R5");
    rd(16'h0260, 8'hFF, "R5");
    rd(16'h0263, 8'hFF, "R5");
    rd(16'h027F, 8'hFF, "R5");
    rd(16'h0280, 8'h55, "R5");
    drain();

    // R7 writes during an operation are ignored
    set_ptr(16'h0300);
    wr_reg(2'd3, 8'h77);
    wr_reg(2'd0, 8'h45);
    @(negedge clk);
    check(rq_ready == 1'b0, "R9", "request blocked while busy", int'(rq_ready), 0);
    wr_reg(2'd0, 8'h4C);
    wr_reg(2'd1, 8'h01);
    wr_reg(2'd3, 8'h88);
    @(negedge clk);
    check(ctl_q == 8'h45, "R7", "ctl_q during busy", int'(ctl_q), 8'h45);
    while (busy) @(negedge clk);
    check(ctl_q == 8'h45, "R7", "ctl_q after op", int'(ctl_q), 8'h45);
    rd(16'h0300, 8'h77, "R7");
    rd(16'h0301, 8'hFF, "R7");
    drain();

    // R8 undefined code starts nothing; retained code does not re-run
    wr_reg(2'd0, 8'h12);
    begin
      int seen = 0;
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (busy || done) seen++;
      end
      check(seen == 0, "R8", "undefined code activity", seen, 0);
    end
    check(ctl_q == 8'h12, "R8", "undefined code stored", int'(ctl_q), 8'h12);
    wr_reg(2'd0, 8'h00);
    @(negedge clk);
    check(ctl_q == 8'h00, "R8", "cleared again", int'(ctl_q), 0);

    // R9 back-pressure on the response
    rs_ready = 1'b0;
    rd(16'h0123, 8'hA5, "R9");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check(rs_valid == 1'b1, "R9", "response held", int'(rs_valid), 1);
      check(rq_ready == 1'b0, "R9", "request stalled", int'(rq_ready), 0);
    end
    @(posedge clk); #1;
    rs_ready = 1'b1;
    drain();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule